// File: doc/BRIEF.md
# Two-Stage Reloadable Watchdog Timer

This block is a down-counting watchdog. Its counter steps down by one on each watchdog tick, a one-cycle enable that arrives roughly every 10.24 ms, and it starts counting as soon as power-up reset is released. Firmware reloads the counter through a single register word. A write takes effect only if a key field in the same word holds all ones.

Expiry happens in two stages. When the counter reaches zero with the expire flag clear, the block sets the flag, gives a short grace reload of 16 and pulses an error output. If the counter reaches zero again while the flag is still set, the block raises a sticky system reset request. Firmware recovers from the first stage by reloading the counter and clearing the flag in one keyed write.

An external freeze input halts counting unless a set-only freeze-disable bit has been written. Firmware normally sets that bit once, during initialisation.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-up reset (rst_n low) the count is 8191. The expire flag, freeze-disable bit, reset request and error pulse are all 0.
- R2: Each tick that is not frozen decrements a non-zero count by one. Without a tick the count holds.
- R3: A write is keyed when wr_data[23:16] is 8'hFF. A keyed write loads the count from wr_data[12:0] and the expire flag from wr_data[24], and it takes effect at the next clock edge.
- R4: A write whose key field is not all ones changes nothing. Bits 23:16 of rd_data always read 0.
- R5: A tick that finds the count at 0 with the expire flag clear sets the flag and reloads the count with 16. It also drives err_pulse high for exactly one cycle.
- R6: A tick that finds the count at 0 with the expire flag set raises rst_req, and the count stays at 0. rst_req stays high, and no write clears it, until a reset.
- R7: While freeze_in is 1 and the freeze-disable bit is 0, ticks do not change the count. rd_data[27] mirrors freeze_in.
- R8: A keyed write with wr_data[25]=1 sets the freeze-disable bit, which reads back at rd_data[25]. A later keyed write with that bit at 0 leaves it set, and while it is set freeze_in is ignored.
- R9: A keyed write in the same cycle as a tick takes priority. The written values are loaded, and the tick has no effect, even at count 0.
- R10: A one-cycle sync_rst returns every state bit to its R1 value, including the freeze-disable bit and rst_req.
- R11: rd_data[26] mirrors rst_req and rd_data[24] mirrors the expire flag. The remaining bits 31:28 and 15:13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sync_rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Watchdog step enable, one cycle wide |
| freeze_in | input | 1 | External request to halt counting |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read word |
| err_pulse | output | 1 | One-cycle pulse at the first-stage expiry |
| expired | output | 1 | Expire flag |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The counter is driven with runs of ticks separated by idle cycles, so that a decrement can be told apart from a held count. Expiry is reached from a small reloaded value, first with the flag clear and then with it set. This separates the grace reload and error pulse from the reset request. Write words are sent with a full key, with one key bit missing, and together with a tick, which shows that the key gates every field and that a write overrides a decrement. The freeze input is held high before and after the disable bit is set, and the bit is then written as 0, to show the mask takes effect and cannot be removed.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int CNT_W   = 13,
  parameter int KEY_W   = 8,
  parameter int KEY_LSB = 16,
  parameter int GRACE   = 16,
  parameter int RST_CNT = 8191
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_rst,
  input  logic        tick,
  input  logic        freeze_in,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        err_pulse,
  output logic        expired,
  output logic        rst_req
);
  localparam int EXP_BIT  = KEY_LSB + KEY_W;
  localparam int FDIS_BIT = EXP_BIT + 1;
  localparam int REQ_BIT  = EXP_BIT + 2;
  localparam int FRZ_BIT  = EXP_BIT + 3;
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);
  localparam logic [CNT_W-1:0] INIT_V  = CNT_W'(RST_CNT);
  localparam logic [31:0] USED_MASK =
    (32'(1) << CNT_W) - 32'd1 | (((32'(1) << KEY_W) - 32'd1) << KEY_LSB) |
    (32'd1 << EXP_BIT) | (32'd1 << FDIS_BIT);

  logic [CNT_W-1:0] cnt;
  logic exp_q, fdis_q, rq_q, err_q;
  logic wr_ok, step, unused_wr;

  assign wr_ok     = wr_en && (wr_data[KEY_LSB +: KEY_W] == {KEY_W{1'b1}});
  assign step      = tick && !(freeze_in && !fdis_q);
  assign unused_wr = ^(wr_data & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= INIT_V; exp_q <= 1'b0; fdis_q <= 1'b0; rq_q <= 1'b0; err_q <= 1'b0;
    end else if (sync_rst) begin
      cnt <= INIT_V; exp_q <= 1'b0; fdis_q <= 1'b0; rq_q <= 1'b0; err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_ok) begin
        cnt    <= wr_data[CNT_W-1:0];
        exp_q  <= wr_data[EXP_BIT];
        fdis_q <= fdis_q | wr_data[FDIS_BIT];
      end else if (step) begin
        if (cnt == '0) begin
          if (!exp_q) begin
            exp_q <= 1'b1;
            cnt   <= GRACE_V;
            err_q <= 1'b1;
          end else begin
            rq_q  <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[CNT_W-1:0] = cnt;
    rd_data[EXP_BIT]   = exp_q;
    rd_data[FDIS_BIT]  = fdis_q;
    rd_data[REQ_BIT]   = rq_q;
    rd_data[FRZ_BIT]   = freeze_in;
  end

  assign err_pulse = err_q;
  assign expired   = exp_q;
  assign rst_req   = rq_q;

  assert_err_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (expired && rd_data[CNT_W-1:0] == GRACE_V));
  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    err_pulse |=> !err_pulse);
  assert_req_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    rst_req |=> rst_req);
  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    (freeze_in && !fdis_q && !wr_en) |=> $stable(cnt));
  assert_fdis_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    fdis_q |=> fdis_q);
  assert_unkeyed_R4: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    (wr_en && !wr_ok && !tick) |=> ($stable(cnt) && $stable(exp_q) && $stable(fdis_q)));
  assert_write_prio_R9: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    wr_ok |=> (cnt == $past(wr_data[CNT_W-1:0]) && exp_q == $past(wr_data[EXP_BIT])));
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, sync_rst = 1'b0, tick = 1'b0, freeze_in = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic err_pulse, expired, rst_req;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdog_two_stage dut_i (.clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .tick(tick),
    .freeze_in(freeze_in), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .err_pulse(err_pulse), .expired(expired), .rst_req(rst_req));

  function automatic logic [31:0] mk(input int c, input bit e, input bit fd, input logic [7:0] k);
    logic [31:0] w = '0;
    w[12:0] = 13'(c); w[23:16] = k; w[24] = e; w[25] = fd;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit we, input logic [31:0] wd);
    @(negedge clk); tick = tk; wr_en = we; wr_data = wd;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0);
  endtask

  task automatic kw(input int c, input bit e, input bit fd);
    cyc(1'b0, 1'b1, mk(c, e, fd, 8'hFF));
  endtask

  task automatic do_sync_rst;
    @(negedge clk); sync_rst = 1'b1;
    @(negedge clk); sync_rst = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", {19'd0, rd_data[12:0]}, 32'd8191);
    check("R1 flags", {28'd0, expired, rst_req, err_pulse, rd_data[25]}, 32'd0);
    check("R11 reserved", rd_data & 32'hF000_E000, 32'd0);
  endtask

  task automatic t_count;
    kw(5, 1'b0, 1'b0);
    check("R3 load", {19'd0, rd_data[12:0]}, 32'd5);
    ticks(1);
    check("R2 dec", {19'd0, rd_data[12:0]}, 32'd4);
    cyc(1'b0, 1'b0, '0); cyc(1'b0, 1'b0, '0);
    check("R2 hold", {19'd0, rd_data[12:0]}, 32'd4);
    ticks(3);
    check("R2 multi", {19'd0, rd_data[12:0]}, 32'd1);
  endtask

  task automatic t_key;
    kw(40, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, mk(100, 1'b1, 1'b1, 8'h7F));
    check("R4 count kept", {19'd0, rd_data[12:0]}, 32'd40);
    check("R4 flags kept", {30'd0, expired, rd_data[25]}, 32'd0);
    cyc(1'b0, 1'b1, mk(100, 1'b0, 1'b0, 8'hFE));
    check("R4 low key bit", {19'd0, rd_data[12:0]}, 32'd40);
    check("R4 key reads 0", {24'd0, rd_data[23:16]}, 32'd0);
    kw(33, 1'b1, 1'b0);
    check("R3 expire write", {31'd0, rd_data[24]}, 32'd1);
    kw(33, 1'b0, 1'b0);
  endtask

  task automatic t_expire;
    kw(1, 1'b0, 1'b0);
    ticks(1);
    check("R2 to zero", {19'd0, rd_data[12:0]}, 32'd0);
    ticks(1);
    check("R5 flag", {31'd0, expired}, 32'd1);
    check("R5 grace", {19'd0, rd_data[12:0]}, 32'd16);
    check("R5 err on", {31'd0, err_pulse}, 32'd1);
    cyc(1'b0, 1'b0, '0);
    check("R5 err off", {31'd0, err_pulse}, 32'd0);
    ticks(16);
    check("R6 no req yet", {30'd0, rst_req, expired}, 32'd1);
    check("R5 no second err", {31'd0, err_pulse}, 32'd0);
    ticks(1);
    check("R6 req", {31'd0, rst_req}, 32'd1);
    check("R11 req bit", {31'd0, rd_data[26]}, 32'd1);
    check("R6 count stays 0", {19'd0, rd_data[12:0]}, 32'd0);
    kw(50, 1'b0, 1'b0);
    ticks(2);
    check("R6 sticky", {31'd0, rst_req}, 32'd1);
    do_sync_rst();
    check("R10 count", {19'd0, rd_data[12:0]}, 32'd8191);
    check("R10 req clr", {30'd0, rst_req, expired}, 32'd0);
    kw(0, 1'b0, 1'b0);
    ticks(1);
    check("R5 write 0/0", {30'd0, expired, rst_req}, 32'd2);
    kw(0, 1'b1, 1'b0);
    ticks(1);
    check("R6 write 0/1", {31'd0, rst_req}, 32'd1);
    do_sync_rst();
  endtask

  task automatic t_freeze;
    freeze_in = 1'b1;
    kw(10, 1'b0, 1'b0);
    ticks(2);
    check("R7 frozen", {19'd0, rd_data[12:0]}, 32'd10);
    check("R7 mirror", {31'd0, rd_data[27]}, 32'd1);
    kw(10, 1'b0, 1'b1);
    check("R8 set", {31'd0, rd_data[25]}, 32'd1);
    ticks(1);
    check("R8 unfrozen", {19'd0, rd_data[12:0]}, 32'd9);
    kw(9, 1'b0, 1'b0);
    check("R8 not cleared", {31'd0, rd_data[25]}, 32'd1);
    freeze_in = 1'b0;
    #1;
    check("R7 mirror low", {31'd0, rd_data[27]}, 32'd0);
    do_sync_rst();
    check("R10 fdis clr", {31'd0, rd_data[25]}, 32'd0);
  endtask

  task automatic t_prio;
    kw(20, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, mk(7, 1'b0, 1'b0, 8'hFF));
    check("R9 write wins", {19'd0, rd_data[12:0]}, 32'd7);
    kw(0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, mk(3, 1'b0, 1'b0, 8'hFF));
    check("R9 zero tick masked", {19'd0, rd_data[12:0]}, 32'd3);
    check("R9 no expire", {30'd0, expired, err_pulse}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_key();
    t_expire();
    t_freeze();
    t_prio();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule